// File: doc/BRIEF.md
# BCD Real-Time Calendar Counter

This block holds the time of day and the calendar date as packed BCD registers and moves them forward by one second each time a single-cycle 1 Hz tick pulse arrives. There are seven fields: seconds, minutes, hours, date within the month, month, day of week and a two-digit year. Carries ripple from seconds up through the year in the same cycle as the tick. The end of each month follows that month's length. February gains a 29th day in years divisible by four, which is correct for every year from 2000 to 2099.

A host sets any field through a one-cycle write port. All fields are visible at all times on parallel outputs. The hours field carries its own format. When bit 7 is set, the hours count in 12-hour form with a PM flag in bit 5. When bit 7 is clear, they count in 24-hour form. The tick comes from a prescaler outside this block.

Top module: `cal_top`

## Requirements
- R1: After reset the fields read seconds 0x00, minutes 0x00, hours 0x00 (24-hour mode), date 0x01, month 0x01, day of week 0x01, year 0x00.
- R2: A write with wrEn high stores wrData into the field picked by wrSel (0 seconds, 1 minutes, 2 hours, 3 date, 4 month, 5 day of week, 6 year) on the next clock edge. Unused bits are forced to zero through the masks 0x7F, 0x7F, 0xBF, 0x3F, 0x1F, 0x07, 0xFF. wrSel 7 changes nothing.
- R3: Seconds and minutes count 00 to 59 in BCD. A tick at second 59 sets seconds to 00 and advances minutes. A tick at 59:59 also sets minutes to 00 and advances the hours.
- R4: In 24-hour mode (hours bit 7 = 0) the hours count 00 to 23. A tick at 23:59:59 sets the hours to 00 and advances both the date and the day of week.
- R5: In 12-hour mode (hours bit 7 = 1, bit 5 = PM) the hours count 12, 01 … 11. The PM flag toggles when the count passes from 11:59:59 to 12:00:00, and 12:59:59 goes to 01:00:00 with the flag kept.
- R6: In 12-hour mode the date and day of week advance only at the 11:59:59 PM to 12:00:00 AM step, never at the AM to PM step.
- R7: At the end of a day, a date equal to the month's last day (30 for months 04, 06, 09, 11; 31 for the others except February) returns to 01 and advances the month. Otherwise the date increments by one.
- R8: February ends on day 29 when the BCD year is divisible by four (including 00), and on day 28 otherwise.
- R9: The day after month 12 day 31 is month 01 day 01, and the year increments, with 99 wrapping to 00.
- R10: The day of week counts 1 to 7 and goes from 7 back to 1.
- R11: A tick arriving in the same cycle as a write is discarded. Only the written field changes in that cycle.
- R12: With no tick and no write, every field holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickIn | input | 1 | One-cycle pulse once per second |
| wrEn | input | 1 | Field write strobe |
| wrSel | input | 3 | Field select for a write |
| wrData | input | 8 | BCD value to write |
| secOut | output | 8 | Seconds |
| minOut | output | 8 | Minutes |
| hourOut | output | 8 | Hours with mode and PM flag |
| dateOut | output | 8 | Date of month |
| monOut | output | 8 | Month |
| dowOut | output | 8 | Day of week |
| yearOut | output | 8 | Year |

## Verification
The assertions check the following on every cycle:
- fields hold when the block is idle;
- the seconds wrap carries into the minutes;
- a last-day rollover returns the date to 01 and moves the month;
- a write leaves the seconds alone unless seconds are the target;
- a 12-hour step out of 11 flips the PM flag;
- the day of week stays within 1 to 7 after it advances.

The actual month lengths, the leap-year choice for particular years, the year and day-of-week wraps, the exact 12-hour sequence and the outcome of a write colliding with a tick can only be shown by the bench's directed scenarios, which load chosen dates and compare results against values worked out by hand.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int FIELD_W = 8;

  typedef enum logic [2:0] {
    SEL_SEC  = 3'd0,
    SEL_MIN  = 3'd1,
    SEL_HOUR = 3'd2,
    SEL_DATE = 3'd3,
    SEL_MON  = 3'd4,
    SEL_DOW  = 3'd5,
    SEL_YEAR = 3'd6
  } fieldSel_e;

  localparam logic [FIELD_W-1:0] MASK_SEC  = 8'h7F;
  localparam logic [FIELD_W-1:0] MASK_MIN  = 8'h7F;
  localparam logic [FIELD_W-1:0] MASK_HOUR = 8'hBF;
  localparam logic [FIELD_W-1:0] MASK_DATE = 8'h3F;
  localparam logic [FIELD_W-1:0] MASK_MON  = 8'h1F;
  localparam logic [FIELD_W-1:0] MASK_DOW  = 8'h07;
  localparam logic [FIELD_W-1:0] MASK_YEAR = 8'hFF;

  typedef struct packed {
    logic incSec;
    logic wrapSec;
    logic incMin;
    logic wrapMin;
    logic stepHour;
    logic incDate;
    logic firstDate;
    logic incMon;
    logic firstMon;
    logic incYear;
    logic incDow;
  } calStrobe_t;

  function automatic logic [FIELD_W-1:0] bcdInc(input logic [FIELD_W-1:0] v);
    logic [FIELD_W-1:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  function automatic logic isLeap(input logic [FIELD_W-1:0] yr);
    logic r;
    if (yr[4]) r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    else       r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    return r;
  endfunction

  function automatic logic [FIELD_W-1:0] monthLast(input logic [FIELD_W-1:0] mon,
                                                   input logic [FIELD_W-1:0] yr);
    logic [FIELD_W-1:0] r;
    case (mon)
      8'h02:                      r = isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

  function automatic logic [FIELD_W-1:0] hourNext(input logic [FIELD_W-1:0] h);
    logic [FIELD_W-1:0] r;
    logic [FIELD_W-1:0] low;
    low = bcdInc({3'b000, h[4:0]});
    if (h[7]) begin
      if (h[4:0] == 5'h12)      r = {h[7:5], 5'h01};
      else if (h[4:0] == 5'h11) r = {h[7], 1'b0, ~h[5], 5'h12};
      else                      r = {h[7:5], low[4:0]};
    end else begin
      if (h[5:0] == 6'h23) r = {h[7:6], 6'h00};
      else begin
        low = bcdInc({2'b00, h[5:0]});
        r   = {h[7:6], low[5:0]};
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               tickIn,
  input  logic               wrEn,
  input  logic [FIELD_W-1:0] secQ,
  input  logic [FIELD_W-1:0] minQ,
  input  logic [FIELD_W-1:0] hourQ,
  input  logic [FIELD_W-1:0] dateQ,
  input  logic [FIELD_W-1:0] monQ,
  input  logic [FIELD_W-1:0] yearQ,
  output calStrobe_t         stb
);

  logic live, secTop, minTop, hourTop, dayEnd, dateTop, monTop;

  // A write in the same cycle swallows the tick (R11)
  assign live    = tickIn && !wrEn;
  assign secTop  = (secQ == 8'h59);
  assign minTop  = (minQ == 8'h59);
  assign hourTop = hourQ[7] ? (hourQ[5] && hourQ[4:0] == 5'h11)
                            : (hourQ[5:0] == 6'h23);
  assign dayEnd  = live && secTop && minTop && hourTop;
  assign dateTop = (dateQ == monthLast(monQ, yearQ));
  assign monTop  = (monQ == 8'h12);

  always_comb begin
    stb           = '0;
    stb.incSec    = live && !secTop;
    stb.wrapSec   = live && secTop;
    stb.incMin    = live && secTop && !minTop;
    stb.wrapMin   = live && secTop && minTop;
    stb.stepHour  = live && secTop && minTop;
    stb.incDow    = dayEnd;
    stb.incDate   = dayEnd && !dateTop;
    stb.firstDate = dayEnd && dateTop;
    stb.incMon    = dayEnd && dateTop && !monTop;
    stb.firstMon  = dayEnd && dateTop && monTop;
    stb.incYear   = dayEnd && dateTop && monTop;
  end

  // R3
  sec_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    live && secTop |=> secQ == 8'h00 && minQ != $past(minQ));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !tickIn && !wrEn |=> $stable(secQ) && $stable(minQ) && $stable(hourQ)
                         && $stable(dateQ) && $stable(monQ) && $stable(yearQ));

  // R7
  month_roll_chk: assert property (@(posedge clk) disable iff (!rstN)
    dayEnd && dateTop |=> dateQ == 8'h01 && monQ != $past(monQ));

endmodule

// File: rtl/cal_dpath.sv
module cal_dpath
  import cal_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [2:0]         wrSel,
  input  logic [FIELD_W-1:0] wrData,
  input  calStrobe_t         stb,
  output logic [FIELD_W-1:0] secQ,
  output logic [FIELD_W-1:0] minQ,
  output logic [FIELD_W-1:0] hourQ,
  output logic [FIELD_W-1:0] dateQ,
  output logic [FIELD_W-1:0] monQ,
  output logic [FIELD_W-1:0] dowQ,
  output logic [FIELD_W-1:0] yearQ
);

  logic hitSec, hitMin, hitHour, hitDate, hitMon, hitDow, hitYear;

  assign hitSec  = wrEn && (wrSel == SEL_SEC);
  assign hitMin  = wrEn && (wrSel == SEL_MIN);
  assign hitHour = wrEn && (wrSel == SEL_HOUR);
  assign hitDate = wrEn && (wrSel == SEL_DATE);
  assign hitMon  = wrEn && (wrSel == SEL_MON);
  assign hitDow  = wrEn && (wrSel == SEL_DOW);
  assign hitYear = wrEn && (wrSel == SEL_YEAR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secQ  <= 8'h00;
      minQ  <= 8'h00;
      hourQ <= 8'h00;
      dateQ <= 8'h01;
      monQ  <= 8'h01;
      dowQ  <= 8'h01;
      yearQ <= 8'h00;
    end else begin
      if (hitSec)           secQ <= wrData & MASK_SEC;
      else if (stb.wrapSec) secQ <= 8'h00;
      else if (stb.incSec)  secQ <= bcdInc(secQ);

      if (hitMin)           minQ <= wrData & MASK_MIN;
      else if (stb.wrapMin) minQ <= 8'h00;
      else if (stb.incMin)  minQ <= bcdInc(minQ);

      if (hitHour)           hourQ <= wrData & MASK_HOUR;
      else if (stb.stepHour) hourQ <= hourNext(hourQ);

      if (hitDate)            dateQ <= wrData & MASK_DATE;
      else if (stb.firstDate) dateQ <= 8'h01;
      else if (stb.incDate)   dateQ <= bcdInc(dateQ);

      if (hitMon)            monQ <= wrData & MASK_MON;
      else if (stb.firstMon) monQ <= 8'h01;
      else if (stb.incMon)   monQ <= bcdInc(monQ);

      if (hitDow)          dowQ <= wrData & MASK_DOW;
      else if (stb.incDow) dowQ <= (dowQ == 8'h07) ? 8'h01 : dowQ + 8'h01;

      if (hitYear)          yearQ <= wrData & MASK_YEAR;
      else if (stb.incYear) yearQ <= (yearQ == 8'h99) ? 8'h00 : bcdInc(yearQ);
    end
  end

  // R11
  wr_isolate_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrEn && wrSel != SEL_SEC |=> $stable(secQ));

  // R5
  pm_flip_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.stepHour && hourQ[7] && hourQ[4:0] == 5'h11 |=> hourQ[5] != $past(hourQ[5]));

  // R10
  dow_span_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.incDow |=> dowQ >= 8'h01 && dowQ <= 8'h07);

endmodule

// File: rtl/cal_top.sv
module cal_top
  import cal_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         tickIn,
  input  logic         wrEn,
  input  logic [2:0]   wrSel,
  input  logic [7:0]   wrData,
  output logic [7:0]   secOut,
  output logic [7:0]   minOut,
  output logic [7:0]   hourOut,
  output logic [7:0]   dateOut,
  output logic [7:0]   monOut,
  output logic [7:0]   dowOut,
  output logic [7:0]   yearOut
);

  calStrobe_t stb;

  cal_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .tickIn (tickIn),
    .wrEn   (wrEn),
    .secQ   (secOut),
    .minQ   (minOut),
    .hourQ  (hourOut),
    .dateQ  (dateOut),
    .monQ   (monOut),
    .yearQ  (yearOut),
    .stb    (stb)
  );

  cal_dpath u_dpath (
    .clk    (clk),
    .rstN   (rstN),
    .wrEn   (wrEn),
    .wrSel  (wrSel),
    .wrData (wrData),
    .stb    (stb),
    .secQ   (secOut),
    .minQ   (minOut),
    .hourQ  (hourOut),
    .dateQ  (dateOut),
    .monQ   (monOut),
    .dowQ   (dowOut),
    .yearQ  (yearOut)
  );

endmodule

// File: tb/sim_cal_top.sv
module sim_cal_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickIn = 1'b0;
  logic       wrEn = 1'b0;
  logic [2:0] wrSel = 3'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] secOut, minOut, hourOut, dateOut, monOut, dowOut, yearOut;
  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  cal_top u0 (
    .clk(clk), .rstN(rstN), .tickIn(tickIn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .secOut(secOut), .minOut(minOut), .hourOut(hourOut),
    .dateOut(dateOut), .monOut(monOut), .dowOut(dowOut), .yearOut(yearOut)
  );

  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tickIn = 1'b1;
    @(negedge clk);
    tickIn = 1'b0;
  endtask

  task automatic setAll(input logic [7:0] s, input logic [7:0] m, input logic [7:0] h,
                        input logic [7:0] d, input logic [7:0] mo, input logic [7:0] w,
                        input logic [7:0] y);
    wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, d);
    wr(3'd4, mo); wr(3'd5, w); wr(3'd6, y);
  endtask

  task automatic testReset();
    chk("R1", "sec", secOut, 8'h00);
    chk("R1", "min", minOut, 8'h00);
    chk("R1", "hour", hourOut, 8'h00);
    chk("R1", "date", dateOut, 8'h01);
    chk("R1", "mon", monOut, 8'h01);
    chk("R1", "dow", dowOut, 8'h01);
    chk("R1", "year", yearOut, 8'h00);
  endtask

  task automatic testWrite();
    setAll(8'h42, 8'h17, 8'h09, 8'h21, 8'h06, 8'h04, 8'h37);
    chk("R2", "sec", secOut, 8'h42);
    chk("R2", "min", minOut, 8'h17);
    chk("R2", "hour", hourOut, 8'h09);
    chk("R2", "date", dateOut, 8'h21);
    chk("R2", "mon", monOut, 8'h06);
    chk("R2", "dow", dowOut, 8'h04);
    chk("R2", "year", yearOut, 8'h37);
    wr(3'd4, 8'hFF);
    chk("R2", "mon mask", monOut, 8'h1F);
    wr(3'd2, 8'hFF);
    chk("R2", "hour mask", hourOut, 8'hBF);
    wr(3'd5, 8'hFF);
    chk("R2", "dow mask", dowOut, 8'h07);
    wr(3'd7, 8'h55);
    chk("R2", "sel7 sec", secOut, 8'h42);
    chk("R2", "sel7 year", yearOut, 8'h37);
  endtask

  task automatic testSecMin();
    setAll(8'h58, 8'h00, 8'h05, 8'h10, 8'h03, 8'h02, 8'h21);
    tick();
    chk("R3", "sec 59", secOut, 8'h59);
    tick();
    chk("R3", "sec wrap", secOut, 8'h00);
    chk("R3", "min inc", minOut, 8'h01);
    setAll(8'h59, 8'h59, 8'h09, 8'h10, 8'h03, 8'h02, 8'h21);
    tick();
    chk("R3", "min wrap", minOut, 8'h00);
    chk("R4", "hour 09->10", hourOut, 8'h10);
    chk("R4", "date held", dateOut, 8'h10);
  endtask

  task automatic testDay24();
    setAll(8'h59, 8'h59, 8'h23, 8'h15, 8'h03, 8'h03, 8'h21);
    tick();
    chk("R4", "hour wrap", hourOut, 8'h00);
    chk("R4", "date inc", dateOut, 8'h16);
    chk("R4", "dow inc", dowOut, 8'h04);
  endtask

  task automatic dayEndCase(input string req, input logic [7:0] d, input logic [7:0] mo,
                            input logic [7:0] y, input logic [7:0] expD,
                            input logic [7:0] expM);
    setAll(8'h59, 8'h59, 8'h23, d, mo, 8'h01, y);
    tick();
    chk(req, "date", dateOut, expD);
    chk(req, "mon", monOut, expM);
  endtask

  task automatic testMonths();
    dayEndCase("R7", 8'h30, 8'h04, 8'h21, 8'h01, 8'h05);
    dayEndCase("R7", 8'h30, 8'h11, 8'h21, 8'h01, 8'h12);
    dayEndCase("R7", 8'h30, 8'h01, 8'h21, 8'h31, 8'h01);
    dayEndCase("R7", 8'h31, 8'h01, 8'h21, 8'h01, 8'h02);
    dayEndCase("R7", 8'h09, 8'h09, 8'h21, 8'h10, 8'h09);
  endtask

  task automatic testLeap();
    dayEndCase("R8", 8'h28, 8'h02, 8'h24, 8'h29, 8'h02);
    dayEndCase("R8", 8'h29, 8'h02, 8'h24, 8'h01, 8'h03);
    dayEndCase("R8", 8'h28, 8'h02, 8'h23, 8'h01, 8'h03);
    dayEndCase("R8", 8'h28, 8'h02, 8'h00, 8'h29, 8'h02);
    dayEndCase("R8", 8'h28, 8'h02, 8'h10, 8'h01, 8'h03);
    dayEndCase("R8", 8'h28, 8'h02, 8'h96, 8'h29, 8'h02);
  endtask

  task automatic testYear();
    dayEndCase("R9", 8'h31, 8'h12, 8'h99, 8'h01, 8'h01);
    chk("R9", "year 99->00", yearOut, 8'h00);
    dayEndCase("R9", 8'h31, 8'h12, 8'h19, 8'h01, 8'h01);
    chk("R9", "year 19->20", yearOut, 8'h20);
  endtask

  task automatic testDow();
    setAll(8'h59, 8'h59, 8'h23, 8'h05, 8'h05, 8'h07, 8'h21);
    tick();
    chk("R10", "dow 7->1", dowOut, 8'h01);
    tick();
    chk("R10", "dow held mid-day", dowOut, 8'h01);
  endtask

  task automatic test12h();
    setAll(8'h59, 8'h59, 8'h91, 8'h08, 8'h08, 8'h02, 8'h21);
    tick();
    chk("R5", "11AM->12PM", hourOut, 8'hB2);
    chk("R6", "date kept at noon", dateOut, 8'h08);
    setAll(8'h59, 8'h59, 8'hB2, 8'h08, 8'h08, 8'h02, 8'h21);
    tick();
    chk("R5", "12PM->01PM", hourOut, 8'hA1);
    setAll(8'h59, 8'h59, 8'h92, 8'h08, 8'h08, 8'h02, 8'h21);
    tick();
    chk("R5", "12AM->01AM", hourOut, 8'h81);
    setAll(8'h59, 8'h59, 8'hA9, 8'h08, 8'h08, 8'h02, 8'h21);
    tick();
    chk("R5", "09PM->10PM", hourOut, 8'hB0);
    setAll(8'h59, 8'h59, 8'hB1, 8'h08, 8'h08, 8'h02, 8'h21);
    tick();
    chk("R6", "11PM->12AM", hourOut, 8'h92);
    chk("R6", "date inc", dateOut, 8'h09);
    chk("R6", "dow inc", dowOut, 8'h03);
  endtask

  task automatic testPriority();
    setAll(8'h10, 8'h20, 8'h05, 8'h10, 8'h03, 8'h02, 8'h21);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd1; wrData = 8'h30; tickIn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickIn = 1'b0;
    chk("R11", "min written", minOut, 8'h30);
    chk("R11", "sec not ticked", secOut, 8'h10);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 3'd0; wrData = 8'h45; tickIn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickIn = 1'b0;
    chk("R11", "sec written not ticked", secOut, 8'h45);
  endtask

  task automatic testHold();
    setAll(8'h33, 8'h44, 8'h12, 8'h22, 8'h07, 8'h06, 8'h55);
    repeat (20) @(negedge clk);
    chk("R12", "sec", secOut, 8'h33);
    chk("R12", "min", minOut, 8'h44);
    chk("R12", "hour", hourOut, 8'h12);
    chk("R12", "date", dateOut, 8'h22);
    chk("R12", "year", yearOut, 8'h55);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite();
    testSecMin();
    testDay24();
    testMonths();
    testLeap();
    testYear();
    testDow();
    test12h();
    testPriority();
    testHold();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!finished) begin
      finished = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule